// File: doc/BRIEF.md
# Sixteen-Line GPIO Controller with Per-Line Interrupt Detection

This block gives software sixteen general-purpose pins behind a small 32-bit register bus with word-aligned, single-cycle writes and reads. Software sets output levels and chooses, line by line, whether a pin drives or receives. It reads pin levels through a two-flop synchronizer. Each line can also be set to raise an interrupt event in one of five trigger styles: two level styles, rising edge, falling edge and any transition.

Events collect in a status register that software clears by writing ones. Lines 0 to 12 each have a dedicated active-high interrupt output that follows their status bit. A clock-select register can hand the two highest lines to an external clock source. While it does so, the controller stops driving those pins.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After the synchronous active-high reset, output data, status, style, clock-select and debounce-select registers hold 0. The direction register holds all ones (every line an input), irq_o is 0, pad_oe is 0 and bus_rdata is 0.
- R2: pad_out carries the output data register. pad_oe[n] is 1 exactly when direction bit n is 0 and line n is not claimed by clock select (direction bit 1 = input, 0 = drive).
- R3: Word offsets are 0x00 output data, 0x04 direction, 0x08 input level, 0x0C status, 0x10 styles of lines 0-7, 0x14 styles of lines 8-15, 0x18 clock select (2 bits) and 0x1C debounce select (2 bits, stored only). A read returns the stored value on bus_rdata on the clock edge after bus_rd_en, unused bits read 0, and bus_rdata is 0 on cycles without a read.
- R4: The input register at 0x08 returns pad_in through two flops: a level applied before edge E0 is returned by a read sampled at edge E2 or later, and not by one sampled at E1.
- R5: Line k (0-7) uses bits [3k+2:3k] of 0x10, and line k+8 uses the same bits of 0x14. Bits 31:24 of both registers ignore writes and read 0.
- R6: Style 0 (active-high level) and style 1 (active-low level) set the status bit on every cycle the synchronized level matches. When a set and a clear fall on the same cycle, the set wins, so a clear takes hold only once the level has gone away.
- R7: Style 2 latches on a synchronized 0-to-1 change, style 3 on 1-to-0, and style 4 on either. The bit stays set until it is cleared, and clearing it while the pin holds still leaves it clear.
- R8: Style codes 5, 6 and 7 never set a status bit.
- R9: Writing a 1 to status bit n clears it, and writing 0 leaves the bit unchanged.
- R10: irq_o is 13 bits wide, and irq_o[n] equals status bit n for lines 0-12. Lines 13-15 latch status but have no interrupt output.
- R11: Clock-select bit 0 claims line 14 and bit 1 claims line 15. clk_sel_o mirrors the register, and a claimed line has pad_oe low. Writing 0 returns both lines to GPIO use.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr_en | input | 1 | Write strobe, one cycle per write |
| bus_rd_en | input | 1 | Read strobe, one cycle per read |
| bus_addr | input | 5 | Byte address; bits 1:0 ignored |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pad_in | input | 16 | Pin levels, asynchronous |
| pad_out | output | 16 | Output levels |
| pad_oe | output | 16 | 1 = drive pad_out onto the pin |
| clk_sel_o | output | 2 | Lines 15/14 handed to clock use |
| irq_o | output | 13 | Active-high interrupt per line 0-12 |

## Verification
The assertions assume that bus_rd_en and bus_wr_en are never high together and that bus_addr is a word-aligned offset inside the map. They also assume pad_in is free to change at any time, since it passes the synchronizer before any check depends on it. The bench drives every bus strobe for exactly one cycle from the falling edge, uses only aligned map offsets, and changes pins only at falling edges. It waits at least four cycles before judging a status bit, except in the one test that probes the exact two-edge input latency.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  // trigger style codes; values 5..7 are reserved
  typedef enum logic [2:0] {
    TRIG_HIGH = 3'd0,
    TRIG_LOW  = 3'd1,
    TRIG_RISE = 3'd2,
    TRIG_FALL = 3'd3,
    TRIG_ANY  = 3'd4
  } trig_t;

  localparam int STYLE_W = 3;

  // word index (byte address bits 4:2)
  localparam logic [2:0] W_DOUT  = 3'd0;
  localparam logic [2:0] W_DIR   = 3'd1;
  localparam logic [2:0] W_LEVEL = 3'd2;
  localparam logic [2:0] W_STAT  = 3'd3;
  localparam logic [2:0] W_STYLO = 3'd4;
  localparam logic [2:0] W_STYHI = 3'd5;
  localparam logic [2:0] W_CLKS  = 3'd6;
  localparam logic [2:0] W_DBS   = 3'd7;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] meta_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      q      <= '0;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/gpio_detect.sv
module gpio_detect
  import gpio_pkg::*;
#(
  parameter int N_LINES = 16
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [N_LINES-1:0]         lvl,
  input  logic [N_LINES*STYLE_W-1:0] style,
  output logic [N_LINES-1:0]         evt
);
  logic [N_LINES-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= lvl;
  end

  for (genvar i = 0; i < N_LINES; i++) begin : g_line
    logic [STYLE_W-1:0] code;
    logic rise, fall;
    assign code = style[i*STYLE_W +: STYLE_W];
    assign rise = lvl[i] & ~prev_q[i];
    assign fall = ~lvl[i] & prev_q[i];
    always_comb begin
      unique case (code)
        TRIG_HIGH: evt[i] = lvl[i];
        TRIG_LOW:  evt[i] = ~lvl[i];
        TRIG_RISE: evt[i] = rise;
        TRIG_FALL: evt[i] = fall;
        TRIG_ANY:  evt[i] = rise | fall;
        default:   evt[i] = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_pkg::*;
#(
  parameter int N_LINES   = 16,
  parameter int IRQ_LINES = 13,
  parameter int DW        = 32,
  parameter int AW        = 5,
  parameter int CLKS_W    = 2,
  parameter int DBS_W     = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 bus_wr_en,
  input  logic                 bus_rd_en,
  input  logic [AW-1:0]        bus_addr,
  input  logic [DW-1:0]        bus_wdata,
  output logic [DW-1:0]        bus_rdata,
  input  logic [N_LINES-1:0]   pad_in,
  output logic [N_LINES-1:0]   pad_out,
  output logic [N_LINES-1:0]   pad_oe,
  output logic [CLKS_W-1:0]    clk_sel_o,
  output logic [IRQ_LINES-1:0] irq_o
);
  localparam int HALF    = N_LINES / 2;
  localparam int STY_REG = HALF * STYLE_W;
  localparam int STY_ALL = N_LINES * STYLE_W;

  logic [N_LINES-1:0] dout_q, dir_q, stat_q;
  logic [STY_ALL-1:0] style_q;
  logic [CLKS_W-1:0]  clks_q;
  logic [DBS_W-1:0]   dbs_q;
  logic [N_LINES-1:0] sync_lvl, line_evt, clr_mask, claim;
  logic [2:0]         widx;

  assign widx = bus_addr[4:2];

  gpio_sync #(.WIDTH(N_LINES)) u_sync (
    .clk(clk), .rst(rst), .d(pad_in), .q(sync_lvl)
  );

  gpio_detect #(.N_LINES(N_LINES)) u_detect (
    .clk(clk), .rst(rst), .lvl(sync_lvl), .style(style_q), .evt(line_evt)
  );

  assign clr_mask = (bus_wr_en && widx == W_STAT) ? bus_wdata[N_LINES-1:0] : '0;

  // top lines may be handed to the clock source
  for (genvar i = 0; i < N_LINES; i++) begin : g_claim
    if (i >= N_LINES - CLKS_W) begin : g_clk
      assign claim[i] = clks_q[i - (N_LINES - CLKS_W)];
    end else begin : g_gpio
      assign claim[i] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dout_q  <= '0;
      dir_q   <= '1;
      stat_q  <= '0;
      style_q <= '0;
      clks_q  <= '0;
      dbs_q   <= '0;
    end else begin
      stat_q <= (stat_q & ~clr_mask) | line_evt;
      if (bus_wr_en) begin
        unique case (widx)
          W_DOUT:  dout_q <= bus_wdata[N_LINES-1:0];
          W_DIR:   dir_q  <= bus_wdata[N_LINES-1:0];
          W_STYLO: style_q[STY_REG-1:0]       <= bus_wdata[STY_REG-1:0];
          W_STYHI: style_q[STY_ALL-1:STY_REG] <= bus_wdata[STY_REG-1:0];
          W_CLKS:  clks_q <= bus_wdata[CLKS_W-1:0];
          W_DBS:   dbs_q  <= bus_wdata[DBS_W-1:0];
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !bus_rd_en) begin
      bus_rdata <= '0;
    end else begin
      unique case (widx)
        W_DOUT:  bus_rdata <= DW'(dout_q);
        W_DIR:   bus_rdata <= DW'(dir_q);
        W_LEVEL: bus_rdata <= DW'(sync_lvl);
        W_STAT:  bus_rdata <= DW'(stat_q);
        W_STYLO: bus_rdata <= DW'(style_q[STY_REG-1:0]);
        W_STYHI: bus_rdata <= DW'(style_q[STY_ALL-1:STY_REG]);
        W_CLKS:  bus_rdata <= DW'(clks_q);
        default: bus_rdata <= DW'(dbs_q);
      endcase
    end
  end

  assign pad_out   = dout_q;
  assign pad_oe    = ~dir_q & ~claim;
  assign clk_sel_o = clks_q;
  assign irq_o     = stat_q[IRQ_LINES-1:0];
endmodule

// File: rtl/gpio_irq_ctrl_chk.sv
module gpio_irq_ctrl_chk #(
  parameter int N_LINES   = 16,
  parameter int IRQ_LINES = 13,
  parameter int DW        = 32,
  parameter int AW        = 5
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 bus_wr_en,
  input logic                 bus_rd_en,
  input logic [AW-1:0]        bus_addr,
  input logic [DW-1:0]        bus_wdata,
  input logic [DW-1:0]        bus_rdata,
  input logic [IRQ_LINES-1:0] irq_o,
  input logic [2:0]           style0,
  input logic [N_LINES-1:0]   evt,
  input logic [N_LINES-1:0]   sync_lvl
);
  logic clr0;
  assign clr0 = bus_wr_en && bus_addr[4:2] == 3'd3 && bus_wdata[0];

  p_reserved_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    (style0 > 3'd4 && !irq_o[0]) |=> !irq_o[0]);

  p_w1c_clear_r9: assert property (@(posedge clk) disable iff (rst)
    (clr0 && !evt[0]) |=> !irq_o[0]);

  p_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    (irq_o[0] && !clr0) |=> irq_o[0]);

  p_event_sets_r6: assert property (@(posedge clk) disable iff (rst)
    evt[0] |=> irq_o[0]);

  p_level_read_r4: assert property (@(posedge clk) disable iff (rst)
    (bus_rd_en && bus_addr[4:2] == 3'd2) |=> bus_rdata == DW'($past(sync_lvl)));

  p_idle_rdata_r3: assert property (@(posedge clk) disable iff (rst)
    !bus_rd_en |=> bus_rdata == '0);
endmodule

bind gpio_irq_ctrl gpio_irq_ctrl_chk #(
  .N_LINES(N_LINES), .IRQ_LINES(IRQ_LINES), .DW(DW), .AW(AW)
) chk_i (
  .clk(clk), .rst(rst), .bus_wr_en(bus_wr_en), .bus_rd_en(bus_rd_en),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .irq_o(irq_o), .style0(style_q[2:0]), .evt(line_evt), .sync_lvl(sync_lvl)
);

// File: tb/gpio_irq_ctrl_tb_top.sv
module gpio_irq_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr_en = 1'b0, bus_rd_en = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [15:0] pad_in = '0, pad_out, pad_oe;
  logic [1:0]  clk_sel_o;
  logic [12:0] irq_o;

  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  gpio_irq_ctrl dut_i (
    .clk(clk), .rst(rst), .bus_wr_en(bus_wr_en), .bus_rd_en(bus_rd_en),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
    .clk_sel_o(clk_sel_o), .irq_o(irq_o)
  );

  localparam logic [4:0] A_DOUT = 5'h00, A_DIR = 5'h04, A_LVL = 5'h08,
    A_STAT = 5'h0C, A_STLO = 5'h10, A_STHI = 5'h14, A_CLK = 5'h18, A_DBS = 5'h1C;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr_en = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr_en = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd_en = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd_en = 1'b0;
    d = bus_rdata;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic test_reset();
    logic [31:0] v;
    chk("R1 irq_o", 32'(irq_o), 0);
    chk("R1 pad_oe", 32'(pad_oe), 0);
    chk("R1 rdata idle", bus_rdata, 0);
    rd(A_DOUT, v); chk("R1 dout", v, 0);
    rd(A_DIR, v);  chk("R1 dir", v, 32'h0000_FFFF);
    rd(A_STAT, v); chk("R1 stat", v, 0);
    rd(A_CLK, v);  chk("R1 clksel", v, 0);
  endtask

  task automatic test_output();
    logic [31:0] v;
    wr(A_DOUT, 32'hFFFF_A5C3);
    wr(A_DIR, 32'h0000_00FF);
    chk("R2 pad_out", 32'(pad_out), 32'h0000_A5C3);
    chk("R2 pad_oe", 32'(pad_oe), 32'h0000_FF00);
    rd(A_DOUT, v); chk("R3 dout readback", v, 32'h0000_A5C3);
    rd(A_DIR, v);  chk("R3 dir readback", v, 32'h0000_00FF);
    wr(A_DBS, 32'hFFFF_FFFF);
    rd(A_DBS, v);  chk("R3 debounce readback", v, 32'h3);
    @(negedge clk);
    chk("R3 rdata zero without read", bus_rdata, 0);
  endtask

  task automatic test_input();
    logic [31:0] v;
    pad_in = 16'h1234;
    rd(A_LVL, v); chk("R4 one edge too early", v, 0);
    rd(A_LVL, v); chk("R4 level after two edges", v, 32'h1234);
    pad_in = 16'h0;
    settle();
    wr(A_STAT, 32'hFFFF);
    rd(A_STAT, v); chk("R9 clear all", v, 0);
  endtask

  task automatic test_styles();
    logic [31:0] v;
    // l0 high, l1 rise, l2 fall, l3 reserved(5), l4 any, l5 low
    wr(A_STLO, 32'hFF00_CAD0);
    rd(A_STLO, v); chk("R5 low style reg", v, 32'h0000_CAD0);
    // line 13 rising
    wr(A_STHI, 32'hFF01_0000);
    rd(A_STHI, v); chk("R5 high style reg", v, 32'h0001_0000);
  endtask

  task automatic test_level();
    logic [31:0] v;
    pad_in[0] = 1'b1; settle();
    rd(A_STAT, v); chk("R6 high level set", 32'(v[0]), 1);
    wr(A_STAT, 32'h1);
    rd(A_STAT, v); chk("R6 clear lost while high", 32'(v[0]), 1);
    pad_in[0] = 1'b0; settle();
    wr(A_STAT, 32'h1);
    rd(A_STAT, v); chk("R6 clear after release", 32'(v[0]), 0);
    rd(A_STAT, v); chk("R6 low level set", 32'(v[5]), 1);
    pad_in[5] = 1'b1; settle();
    wr(A_STAT, 32'h20);
    rd(A_STAT, v); chk("R6 low level cleared", 32'(v[5]), 0);
  endtask

  task automatic test_edges();
    logic [31:0] v;
    pad_in[1] = 1'b1; settle();
    rd(A_STAT, v); chk("R7 rising set", 32'(v[1]), 1);
    wr(A_STAT, 32'h2); settle();
    rd(A_STAT, v); chk("R7 rising stays clear", 32'(v[1]), 0);
    pad_in[1] = 1'b0; settle();
    rd(A_STAT, v); chk("R7 rising ignores fall", 32'(v[1]), 0);
    pad_in[2] = 1'b1; settle();
    rd(A_STAT, v); chk("R7 falling ignores rise", 32'(v[2]), 0);
    pad_in[2] = 1'b0; settle();
    rd(A_STAT, v); chk("R7 falling set", 32'(v[2]), 1);
    wr(A_STAT, 32'h4);
    pad_in[4] = 1'b1; settle();
    rd(A_STAT, v); chk("R7 any on rise", 32'(v[4]), 1);
    wr(A_STAT, 32'h10);
    pad_in[4] = 1'b0; settle();
    rd(A_STAT, v); chk("R7 any on fall", 32'(v[4]), 1);
    wr(A_STAT, 32'h10);
  endtask

  task automatic test_reserved();
    logic [31:0] v;
    pad_in[3] = 1'b1; settle();
    pad_in[3] = 1'b0; settle();
    rd(A_STAT, v); chk("R8 reserved code 5 quiet", 32'(v[3]), 0);
  endtask

  task automatic test_w1c();
    logic [31:0] v;
    pad_in[4] = 1'b1; pad_in[1] = 1'b1; settle();
    wr(A_STAT, 32'h0);
    rd(A_STAT, v); chk("R9 write zero keeps", v & 32'h12, 32'h12);
    wr(A_STAT, 32'h10);
    rd(A_STAT, v); chk("R9 clears only ones", v & 32'h12, 32'h02);
    wr(A_STAT, 32'h2);
  endtask

  task automatic test_irq();
    logic [31:0] v;
    pad_in[13] = 1'b1; pad_in[1] = 1'b0; settle();
    pad_in[1] = 1'b1; settle();
    rd(A_STAT, v); chk("R10 line 13 latches", 32'(v[13]), 1);
    chk("R10 irq_o mirrors lines 0-12", 32'(irq_o), 32'h0002);
    wr(A_STAT, 32'hFFFF);
    chk("R10 irq_o cleared", 32'(irq_o), 0);
  endtask

  task automatic test_clksel();
    logic [31:0] v;
    wr(A_DIR, 32'h0);
    chk("R11 all driven", 32'(pad_oe), 32'hFFFF);
    wr(A_CLK, 32'h1);
    chk("R11 line 14 claimed", 32'(pad_oe), 32'hBFFF);
    chk("R11 clk_sel_o one", 32'(clk_sel_o), 1);
    wr(A_CLK, 32'hFFFF_FFFF);
    chk("R11 both claimed", 32'(pad_oe), 32'h3FFF);
    rd(A_CLK, v); chk("R11 clksel readback", v, 3);
    wr(A_CLK, 32'h0);
    chk("R11 released", 32'(pad_oe), 32'hFFFF);
    chk("R11 clk_sel_o zero", 32'(clk_sel_o), 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    test_reset();
    test_output();
    test_input();
    test_styles();
    test_level();
    test_edges();
    test_reserved();
    test_w1c();
    test_irq();
    test_clksel();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #2_000_000;
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule